// File: doc/BRIEF.md
# Two-Point ADC Gain and Offset Corrector

This unit corrects the gain and offset error of an N-bit converter by using two known reference levels. A calibration request carries two raw codes in one handshake beat. The first is the code read for an input at one quarter of full scale. The second is the code read for an input at three quarters of full scale. From these codes the unit computes a gain held in millionths and a signed integer offset. It then applies both to every raw sample it accepts afterwards.

A single restoring divider does all of the arithmetic and produces one quotient bit per clock. It forms the gain, then the offset term during calibration, and then the per-sample scaling in normal operation. While the divider is in use, both ready outputs are low. A successful calibration ends with a one-cycle done pulse. A rejected calibration ends with a one-cycle error pulse. Corrected samples come out as one-cycle valid pulses and are saturated to the converter range.

Top module: `adc_twopoint_cal`

## Requirements
- R1: After reset and before any calibration, the gain is 1,000,000 and the offset is 0, so each corrected sample equals its masked raw code.
- R2: Only the low N bits of `smp_raw` are used. Bits N and above have no effect on the result.
- R3: On a calibration with `ref_hi > ref_lo`, the gain becomes (3·2^N/4 − 2^N/4)·1,000,000 / (ref_hi − ref_lo), with the division truncated.
- R4: The offset becomes 2^N/4 − (ref_lo·gain / 1,000,000). Each sample is corrected as (raw·gain / 1,000,000) + offset, and both divisions truncate toward zero.
- R5: A calibration with `ref_hi <= ref_lo` raises `cal_err` for one cycle, gives no `cal_done`, and keeps the previous gain and offset.
- R6: A corrected value below 0 comes out as 0. A value above 2^N − 1 comes out as 2^N − 1.
- R7: `smp_ready` and `ref_ready` are low from the cycle after a sample or a valid calibration is accepted until its result is produced. Each accepted sample yields exactly one single-cycle `out_valid`.
- R8: While `ref_valid` is high, `smp_ready` is low, so a calibration request wins over a sample.
- R9: `cal_done` pulses for one cycle after the new gain and offset are in place, and every later sample uses them. `cal_done` and `cal_err` never pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_valid | input | 1 | Calibration request valid |
| ref_ready | output | 1 | Unit can accept a calibration request |
| ref_lo | input | N | Raw code measured at the quarter-scale reference |
| ref_hi | input | N | Raw code measured at the three-quarter-scale reference |
| smp_valid | input | 1 | Raw sample valid |
| smp_ready | output | 1 | Unit can accept a raw sample |
| smp_raw | input | RAW_W | Raw sample; only the low N bits are used |
| out_valid | output | 1 | One-cycle strobe for a corrected sample |
| out_data | output | N | Corrected, saturated sample |
| cal_done | output | 1 | One-cycle pulse when a calibration has been applied |
| cal_err | output | 1 | One-cycle pulse when a calibration is rejected |

## Verification
Identity samples taken right after reset show whether the reset coefficients are exact, because any rounding in the divider path would show up as an off-by-one. Random 16-bit raw words with random upper bits separate correct masking from leakage of bits above N. Random calibrations with widely varying reference spreads check the gain and offset arithmetic against an integer model over many quotient sizes.

Three directed cases cover behaviour the random stream rarely reaches:
- A narrow reference spread with a large low code drives the result past both range limits.
- Equal and inverted reference codes must leave the earlier coefficients in force.
- Requests that arrive together must resolve in favour of calibration.

// File: rtl/adc_twopoint_cal.sv
module adc_twopoint_cal #(
  parameter int N     = 10,
  parameter int RAW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_valid,
  output logic             ref_ready,
  input  logic [N-1:0]     ref_lo,
  input  logic [N-1:0]     ref_hi,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [RAW_W-1:0] smp_raw,
  output logic             out_valid,
  output logic [N-1:0]     out_data,
  output logic             cal_done,
  output logic             cal_err
);
  localparam int SCW = 32;
  localparam int DW  = RAW_W + SCW;
  localparam int CW  = $clog2(DW + 1);
  localparam logic [SCW-1:0] ONE_M = SCW'(1000000);
  localparam logic [DW-1:0] NSPAN_M = DW'(64'd1000000 << (N - 1));
  localparam logic signed [DW+1:0] NLO_S = (DW+2)'(2 ** (N - 2));
  localparam logic signed [DW+1:0] MAXC  = (DW+2)'(2 ** N - 1);
  localparam logic [RAW_W-1:0] RMASK = RAW_W'(2 ** N - 1);

  typedef enum logic [1:0] {S_IDLE, S_SCALE, S_BIAS, S_SMP} st_t;

  st_t                    st;
  logic [SCW-1:0]         scale, new_scale, den;
  logic signed [DW+1:0]   bias;
  logic [N-1:0]           lo_r;
  logic [DW-1:0]          dq;
  logic [SCW:0]           rem;
  logic [CW-1:0]          cnt;

  assign ref_ready = (st == S_IDLE);
  assign smp_ready = (st == S_IDLE) && !ref_valid;

  wire              ref_go = ref_valid && ref_ready;
  wire              smp_go = smp_valid && smp_ready;
  wire [RAW_W-1:0]  raw_m  = smp_raw & RMASK;

  wire [SCW+1:0]    trial = {rem, dq[DW-1]} - {2'b00, den};
  wire              take  = !trial[SCW+1];

  wire signed [DW+1:0] q_s  = signed'({2'b00, dq});
  wire signed [DW+1:0] corr = q_s + bias;
  wire [N-1:0] clamped = (corr < 0) ? '0 : (corr > MAXC) ? '1 : corr[N-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      scale     <= ONE_M;
      new_scale <= '0;
      bias      <= '0;
      lo_r      <= '0;
      dq        <= '0;
      rem       <= '0;
      den       <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      cal_done  <= 1'b0;
      cal_err   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      cal_done  <= 1'b0;
      cal_err   <= 1'b0;
      if (st == S_IDLE) begin
        if (ref_go) begin
          if (ref_hi <= ref_lo) begin
            cal_err <= 1'b1;
          end else begin
            lo_r <= ref_lo;
            dq   <= NSPAN_M;
            den  <= SCW'(ref_hi - ref_lo);
            rem  <= '0;
            cnt  <= CW'(DW);
            st   <= S_SCALE;
          end
        end else if (smp_go) begin
          dq  <= DW'(raw_m) * DW'(scale);
          den <= ONE_M;
          rem <= '0;
          cnt <= CW'(DW);
          st  <= S_SMP;
        end
      end else if (cnt != '0) begin
        rem <= take ? trial[SCW:0] : {rem[SCW-1:0], dq[DW-1]};
        dq  <= {dq[DW-2:0], take};
        cnt <= cnt - 1'b1;
      end else begin
        case (st)
          S_SCALE: begin
            new_scale <= dq[SCW-1:0];
            dq  <= DW'(lo_r) * DW'(dq[SCW-1:0]);
            den <= ONE_M;
            rem <= '0;
            cnt <= CW'(DW);
            st  <= S_BIAS;
          end
          S_BIAS: begin
            scale    <= new_scale;
            bias     <= NLO_S - q_s;
            cal_done <= 1'b1;
            st       <= S_IDLE;
          end
          S_SMP: begin
            out_data  <= clamped;
            out_valid <= 1'b1;
            st        <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_twopoint_cal_chk.sv
module adc_twopoint_cal_chk #(
  parameter int N = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ref_valid,
  input logic         ref_ready,
  input logic [N-1:0] ref_lo,
  input logic [N-1:0] ref_hi,
  input logic         smp_valid,
  input logic         smp_ready,
  input logic         out_valid,
  input logic         cal_done,
  input logic         cal_err
);
  AST_BAD_REF_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && ref_ready && (ref_hi <= ref_lo)) |=> (cal_err && !cal_done)); // R5
  AST_SMP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> (!smp_ready && !ref_ready)); // R7
  AST_REF_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && ref_ready && (ref_hi > ref_lo)) |=> (!smp_ready && !ref_ready)); // R7
  AST_OUT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R7
  AST_REF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |-> !smp_ready); // R8
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cal_done && cal_err)); // R9
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> $past(!ref_ready)); // R9
endmodule

bind adc_twopoint_cal adc_twopoint_cal_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_ready(ref_ready),
  .ref_lo(ref_lo), .ref_hi(ref_hi), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .out_valid(out_valid), .cal_done(cal_done), .cal_err(cal_err)
);

// File: tb/adc_twopoint_cal_test.sv
module adc_twopoint_cal_test;
  localparam int N = 10;
  localparam int RAW_W = 16;
  localparam longint NL = (64'd1 << N) / 4;
  localparam longint NH = 3 * (64'd1 << N) / 4;
  localparam longint MAXV = (64'd1 << N) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_valid = 1'b0, smp_valid = 1'b0;
  logic [N-1:0] ref_lo = '0, ref_hi = '0;
  logic [RAW_W-1:0] smp_raw = '0;
  logic ref_ready, smp_ready, out_valid, cal_done, cal_err;
  logic [N-1:0] out_data;

  int checks = 0, fails = 0, cyc = 0;
  longint m_scale = 1000000, m_bias = 0;

  adc_twopoint_cal #(.N(N), .RAW_W(RAW_W)) uut (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_ready(ref_ready),
    .ref_lo(ref_lo), .ref_hi(ref_hi), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_raw(smp_raw), .out_valid(out_valid), .out_data(out_data),
    .cal_done(cal_done), .cal_err(cal_err));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic longint exp_out(longint raw);
    longint v;
    v = (raw & MAXV) * m_scale / 1000000 + m_bias;
    if (v < 0) v = 0;
    if (v > MAXV) v = MAXV;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, expv);
    end
  endtask

  task automatic sample(input logic [RAW_W-1:0] raw, input string req);
    int n = 0;
    longint e;
    e = exp_out(longint'(raw));
    @(negedge clk);
    smp_raw = raw; smp_valid = 1'b1;
    while (!smp_ready) @(negedge clk);
    @(negedge clk);
    smp_valid = 1'b0;
    chk(smp_ready == 1'b0, "R7 ready low while busy", longint'(smp_ready), 0);
    while (!out_valid && n < 500) begin @(negedge clk); n++; end
    chk(out_valid && longint'(out_data) == e, req, longint'(out_data), e);
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 single out_valid", longint'(out_valid), 0);
  endtask

  task automatic calibrate(input int lo, input int hi);
    int n = 0;
    bit good;
    good = (hi > lo);
    @(negedge clk);
    ref_lo = N'(lo); ref_hi = N'(hi); ref_valid = 1'b1;
    while (!ref_ready) @(negedge clk);
    @(negedge clk);
    ref_valid = 1'b0;
    if (good)
      chk(ref_ready == 1'b0, "R7 ref_ready low while busy", longint'(ref_ready), 0);
    while (!cal_done && !cal_err && n < 500) begin @(negedge clk); n++; end
    if (good) begin
      chk(cal_done && !cal_err, "R9 cal_done on good calibration",
          longint'({cal_done, cal_err}), 2);
      m_scale = (NH - NL) * 1000000 / longint'(hi - lo);  // R3
      m_bias  = NL - longint'(lo) * m_scale / 1000000;    // R4
    end else begin
      chk(cal_err && !cal_done, "R5 cal_err on bad calibration",
          longint'({cal_done, cal_err}), 1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ref_ready && smp_ready && !out_valid && !cal_done && !cal_err,
        "R1 reset state", longint'({ref_ready, smp_ready, out_valid, cal_done, cal_err}), 5'b11000);

    sample(16'd0, "R1 identity zero");
    sample(16'd1023, "R1 identity full");
    sample(16'd517, "R1 identity mid");
    sample(16'hFC05, "R2 upper bits masked");
    sample(16'h0400, "R2 bit N ignored");

    calibrate(200, 840);
    sample(16'd200, "R4 low reference maps near quarter");
    sample(16'd840, "R3 high reference maps near three quarters");
    sample(16'd12345, "R4 corrected sample");

    calibrate(300, 300);
    sample(16'd600, "R5 equal refs keep coefficients");
    calibrate(700, 100);
    sample(16'd50, "R5 inverted refs keep coefficients");

    calibrate(500, 600);
    sample(16'd0, "R6 clamp at zero");
    sample(16'd1023, "R6 clamp at full scale");
    sample(16'd550, "R6 in-range value");

    @(negedge clk);
    ref_lo = N'(9); ref_hi = N'(4); ref_valid = 1'b1; smp_valid = 1'b1; smp_raw = 16'd700;
    #1;
    chk(smp_ready == 1'b0, "R8 sample held off by calibration", longint'(smp_ready), 0);
    @(negedge clk);
    chk(cal_err == 1'b1 && out_valid == 1'b0, "R8 calibration taken first",
        longint'({cal_err, out_valid}), 2);
    ref_valid = 1'b0;
    sample(16'd700, "R8 sample served afterwards");

    for (int c = 0; c < 20; c++) begin
      int lo, hi;
      lo = int'($urandom_range(0, 1020));
      hi = lo + int'($urandom_range(1, 1023 - lo));
      if ((c % 5) == 4) calibrate(hi, lo); else calibrate(lo, hi);
      for (int s = 0; s < 8; s++)
        sample(RAW_W'($urandom), "R4 random corrected sample");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule